// File: doc/BRIEF.md
# Status-Polled Flash Bank Programmer

This controller erases or programs one bank of a byte-wide flash device that takes command bytes and reports progress through a status register. For an erase it sends the two-byte erase command. For a program it writes each byte of the bank in turn: a setup command, a programmable settling wait, then the data byte. After every device operation it keeps reading status until the device reports ready, reports an error, or the poll budget runs out.

Once the device has finished, the controller clears the status, puts the device back into array-read mode and reads the whole bank back. An erase must read back as all 0xFF. A program must match the source data, which the controller fetches again through a byte request/response port.

A one-cycle `start_i` pulse starts an operation and `op_prog_i` selects erase or program. The outcome is shown on `result_o` and stays there until the next start. `done_o` pulses for one cycle when the operation ends.

Top module: `flash_bank_prog`

## Requirements
- R1: An accepted erase request first writes 0x20 and then 0xD0 to bank offset 0, in two consecutive cycles.
- R2: A status poll writes 0x70 to offset 0 and reads offset 0 in the next cycle. A read value with bit 7 (0x80) set means the device is ready.
- R3: A status read with any bit of mask 0x38 set ends the wait at once with result 2 (device error). This holds whether or not bit 7 is set.
- R4: A single wait makes at most POLL_LIMIT status reads. If none of them reports ready, the result is 1 (timeout). A program that times out issues no writes for the remaining bytes.
- R5: When the device operation ends, whatever the outcome, the controller writes 0x50 and then 0xFF to offset 0. After a timeout or device error, the operation ends with no readback.
- R6: Bytes are programmed in ascending address order. Each byte gets 0x40 written to its address, then the source byte written to the same address exactly SETUP_WAIT+1 cycles later, then a status wait.
- R7: The erase readback reads addresses in ascending order and expects 0xFF. The first mismatch ends the operation with result 3 (verify failure) and no further reads.
- R8: The program readback compares each byte with the source data fetched again for that address, with the same first-mismatch rule and result 3. A clean readback gives result 0.
- R9: `done_o` is high for exactly one cycle, after which `busy_o` is low. `result_o` keeps its value until the next accepted start.
- R10: A start pulse while `busy_o` is high is ignored and does not alter the bus sequence in progress.
- R11: After reset the block is idle, with no bus strobe, no source request and `done_o` low.
- R12: There is at most one bus access per cycle, and write and read strobes are never high together. Flash read data and source data are sampled one cycle after their request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| op_prog_i | input | 1 | 1 = program, 0 = erase; sampled with start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| result_o | output | 2 | 0 ok, 1 timeout, 2 device error, 3 verify failure |
| src_req_o | output | 1 | Source byte request |
| src_addr_o | output | AW | Source byte address |
| src_data_i | input | 8 | Source byte, valid the cycle after request |
| fl_addr_o | output | AW | Flash byte address within the bank |
| fl_wdata_o | output | 8 | Flash write data |
| fl_we_o | output | 1 | Flash write strobe |
| fl_re_o | output | 1 | Flash read strobe |
| fl_rdata_i | input | 8 | Flash read data, valid the cycle after read strobe |

## Verification
The bench aims at the edges of the poll budget. With exactly POLL_LIMIT-1 not-ready reads the operation must succeed; a controller that checks the limit before the ready bit would falsely report a timeout. With POLL_LIMIT not-ready reads it must time out; an off-by-one design would make one poll too many or too few.

A device that stays busy during a program must stop the byte loop at byte 0. A design that ignores the timeout would go on writing. An error status must end the wait even when it arrives together with the ready bit. Readback corruption is injected at offset 5 and at the last byte, so a design that skips the first-mismatch stop, or never compares the final byte, shows a wrong read count or result.

The gap between setup and data writes is timed to the cycle. A start pulse is also applied mid-program and must leave the bus sequence unchanged.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_CLEAR       = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] STAT_READY      = 8'h80;
  localparam logic [7:0] STAT_ERR_MASK   = 8'h38;

  typedef enum logic [3:0] {
    S_IDLE, S_ER_SETUP, S_ER_GO, S_PG_SETUP, S_PG_WAIT, S_PG_DATA,
    S_POLL_CMD, S_POLL_RD, S_POLL_CHK, S_CLR, S_RST, S_VFY_RD, S_VFY_CHK, S_FIN
  } fbp_state_e;

  typedef enum logic [1:0] {
    RES_OK = 2'd0, RES_TIMEOUT = 2'd1, RES_DEVERR = 2'd2, RES_VERIFY = 2'd3
  } fbp_result_e;
endpackage

// File: rtl/fbp_poll_ctr.sv
module fbp_poll_ctr #(
  parameter int LIMIT = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic limit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // reached on the LIMIT-th status read of this wait
  assign limit_o = (cnt_q == CW'(LIMIT - 1));

  assert_poll_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/fbp_delay.sv
module fbp_delay #(
  parameter int CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int DW = $clog2(CYCLES + 1);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= DW'(CYCLES - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  assert_wait_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == DW'(CYCLES - 1)));
endmodule

// File: rtl/fbp_addr_ctr.sv
module fbp_addr_ctr #(
  parameter int BYTES = 8192
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     inc_i,
  output logic [$clog2(BYTES)-1:0] addr_o,
  output logic                     last_o
);
  localparam int AW = $clog2(BYTES);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (inc_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == AW'(BYTES - 1));
endmodule

// File: rtl/flash_bank_prog.sv
module flash_bank_prog
  import fbp_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int POLL_LIMIT = 1000000,
  parameter int SETUP_WAIT = 100,
  localparam int AW = $clog2(BANK_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          op_prog_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o,
  output logic          src_req_o,
  output logic [AW-1:0] src_addr_o,
  input  logic [7:0]    src_data_i,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_wdata_o,
  output logic          fl_we_o,
  output logic          fl_re_o,
  input  logic [7:0]    fl_rdata_i
);
  fbp_state_e  state_q, state_d;
  fbp_result_e res_q, res_d;
  logic        op_q;
  logic        src_pend_q;
  logic [7:0]  data_q;
  logic [AW-1:0] addr;
  logic        addr_last, addr_clr, addr_inc;
  logic        poll_clr, poll_inc, poll_limit;
  logic        wait_load, wait_done;
  logic        start_ok;

  assign start_ok = start_i && (state_q == S_IDLE);

  fbp_addr_ctr #(.BYTES(BANK_BYTES)) u_addr (
    .clk_i, .rst_ni, .clr_i(addr_clr), .inc_i(addr_inc),
    .addr_o(addr), .last_o(addr_last));

  fbp_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk_i, .rst_ni, .clr_i(poll_clr), .inc_i(poll_inc), .limit_o(poll_limit));

  fbp_delay #(.CYCLES(SETUP_WAIT)) u_wait (
    .clk_i, .rst_ni, .load_i(wait_load), .expired_o(wait_done));

  always_comb begin
    state_d  = state_q;
    res_d    = res_q;
    addr_clr = 1'b0;
    addr_inc = 1'b0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        res_d    = RES_OK;
        addr_clr = 1'b1;
        state_d  = op_prog_i ? S_PG_SETUP : S_ER_SETUP;
      end
      S_ER_SETUP: state_d = S_ER_GO;
      S_ER_GO:    begin poll_clr = 1'b1; state_d = S_POLL_CMD; end
      S_PG_SETUP: state_d = S_PG_WAIT;
      S_PG_WAIT:  if (wait_done) state_d = S_PG_DATA;
      S_PG_DATA:  begin poll_clr = 1'b1; state_d = S_POLL_CMD; end
      S_POLL_CMD: state_d = S_POLL_RD;
      S_POLL_RD:  state_d = S_POLL_CHK;
      S_POLL_CHK: begin
        // error bits win over ready; ready wins over the poll limit
        if ((fl_rdata_i & STAT_ERR_MASK) != 8'h00) begin
          res_d = RES_DEVERR; state_d = S_CLR;
        end else if ((fl_rdata_i & STAT_READY) != 8'h00) begin
          if (op_q && !addr_last) begin addr_inc = 1'b1; state_d = S_PG_SETUP; end
          else state_d = S_CLR;
        end else if (poll_limit) begin
          res_d = RES_TIMEOUT; state_d = S_CLR;
        end else begin
          poll_inc = 1'b1; state_d = S_POLL_CMD;
        end
      end
      S_CLR: begin addr_clr = 1'b1; state_d = S_RST; end
      S_RST: state_d = (res_q == RES_OK) ? S_VFY_RD : S_FIN;
      S_VFY_RD: state_d = S_VFY_CHK;
      S_VFY_CHK: begin
        if (fl_rdata_i != (op_q ? src_data_i : 8'hFF)) begin
          res_d = RES_VERIFY; state_d = S_FIN;
        end else if (addr_last) state_d = S_FIN;
        else begin addr_inc = 1'b1; state_d = S_VFY_RD; end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign wait_load = (state_q == S_PG_SETUP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      res_q      <= RES_OK;
      op_q       <= 1'b0;
      src_pend_q <= 1'b0;
      data_q     <= 8'h00;
    end else begin
      state_q    <= state_d;
      res_q      <= res_d;
      src_pend_q <= src_req_o;
      if (start_ok)   op_q   <= op_prog_i;
      if (src_pend_q) data_q <= src_data_i;
    end
  end

  always_comb begin
    fl_we_o    = 1'b0;
    fl_re_o    = 1'b0;
    fl_addr_o  = '0;
    fl_wdata_o = 8'h00;
    case (state_q)
      S_ER_SETUP: begin fl_we_o = 1'b1; fl_wdata_o = CMD_ERASE_SETUP; end
      S_ER_GO:    begin fl_we_o = 1'b1; fl_wdata_o = CMD_ERASE_GO; end
      S_PG_SETUP: begin fl_we_o = 1'b1; fl_addr_o = addr; fl_wdata_o = CMD_PROG_SETUP; end
      S_PG_DATA:  begin fl_we_o = 1'b1; fl_addr_o = addr; fl_wdata_o = data_q; end
      S_POLL_CMD: begin fl_we_o = 1'b1; fl_wdata_o = CMD_STATUS; end
      S_POLL_RD:  fl_re_o = 1'b1;
      S_CLR:      begin fl_we_o = 1'b1; fl_wdata_o = CMD_CLEAR; end
      S_RST:      begin fl_we_o = 1'b1; fl_wdata_o = CMD_READ_ARRAY; end
      S_VFY_RD:   begin fl_re_o = 1'b1; fl_addr_o = addr; end
      default: ;
    endcase
  end

  assign src_req_o  = (state_q == S_PG_SETUP) || (op_q && state_q == S_VFY_RD);
  assign src_addr_o = addr;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_FIN);
  assign result_o   = res_q;

  assert_bus_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_re_o));
  assert_erase_pair_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_o && fl_wdata_o == CMD_ERASE_SETUP && !op_q) |=> (fl_we_o && fl_wdata_o == CMD_ERASE_GO));
  assert_poll_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POLL_CMD) |=> (fl_re_o && fl_addr_o == '0));
  assert_clr_then_rst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_o && state_q == S_CLR) |=> (fl_we_o && fl_wdata_o == CMD_READ_ARRAY && fl_addr_o == '0));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(result_o));
  assert_src_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_req_o |-> busy_o);
  assert_op_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != S_FIN) |=> $stable(op_q));
endmodule

// File: tb/sim_flash_bank_prog.sv
module sim_flash_bank_prog;
  localparam int N   = 16;
  localparam int AW  = $clog2(N);
  localparam int LIM = 6;
  localparam int SW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_prog = 1'b0;
  logic busy, done, src_req, fl_we, fl_re;
  logic [1:0] result;
  logic [AW-1:0] src_addr, fl_addr;
  logic [7:0] src_data = 8'h00, fl_wdata, fl_rdata = 8'h00;

  always #5 clk = ~clk;

  flash_bank_prog #(.BANK_BYTES(N), .POLL_LIMIT(LIM), .SETUP_WAIT(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_prog_i(op_prog),
    .busy_o(busy), .done_o(done), .result_o(result),
    .src_req_o(src_req), .src_addr_o(src_addr), .src_data_i(src_data),
    .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_we_o(fl_we), .fl_re_o(fl_re),
    .fl_rdata_i(fl_rdata));

  int tests = 0, fails = 0, cyc = 0;
  int exp_q[$];

  // device model knobs
  int   m_busy = 0;
  bit   m_stuck = 1'b0;
  logic [7:0] m_err = 8'h00;
  int   m_corrupt = -1;
  int   seed = 0;

  logic [7:0] mem [N];
  bit   smode = 1'b0;
  logic [7:0] pend_cmd = 8'h00;
  int   busy_cnt = 0;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + seed) ^ 8'h5A);
  endfunction

  function automatic int enc(int k, int a, int d);
    return (k << 24) | (a << 8) | d;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (src_req) src_data <= pat(int'(src_addr));
    if (fl_re) begin
      if (smode) begin
        if (m_stuck) fl_rdata <= 8'h00;
        else if (busy_cnt > 0) begin busy_cnt--; fl_rdata <= 8'h00; end
        else fl_rdata <= 8'h80 | m_err;
      end else fl_rdata <= mem[fl_addr];
    end
    if (fl_we) begin
      if (pend_cmd == 8'h40) begin
        mem[fl_addr] = (int'(fl_addr) == m_corrupt) ? (fl_wdata ^ 8'h01) : fl_wdata;
        busy_cnt = m_busy; smode = 1'b1; pend_cmd = 8'h00;
      end else if (pend_cmd == 8'h20 && fl_wdata == 8'hD0) begin
        for (int i = 0; i < N; i++) mem[i] = (i == m_corrupt) ? 8'h00 : 8'hFF;
        busy_cnt = m_busy; smode = 1'b1; pend_cmd = 8'h00;
      end else begin
        case (fl_wdata)
          8'h20, 8'h40: pend_cmd = fl_wdata;
          8'h70: smode = 1'b1;
          8'hFF: smode = 1'b0;
          default: ;
        endcase
      end
    end
  end

  // bus monitor: every access is compared with the reference sequence
  bit setup_pend = 1'b0;
  int setup_cyc = 0;
  always @(negedge clk) if (rst_n) begin
    if (fl_we && fl_re) begin
      tests++; fails++;
      $display("FAIL R12: we=%0b re=%0b expected exclusive", fl_we, fl_re);
    end
    if (fl_we || fl_re) begin
      int act;
      act = fl_we ? enc(1, int'(fl_addr), int'(fl_wdata)) : enc(2, int'(fl_addr), 0);
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL bus seq (R1 R2 R5 R6 R7 R8 R10): got %h expected none", act);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != act) begin
          fails++;
          $display("FAIL bus seq (R1 R2 R5 R6 R7 R8 R10): got %h expected %h", act, e);
        end
      end
      if (fl_we) begin
        if (setup_pend) begin
          setup_pend = 1'b0;
          tests++;
          if (cyc - setup_cyc != SW + 1) begin
            fails++;
            $display("FAIL R6: setup-to-data gap %0d expected %0d", cyc - setup_cyc, SW + 1);
          end
        end else if (fl_wdata == 8'h40) begin
          setup_pend = 1'b1; setup_cyc = cyc;
        end
      end
    end
  end

  task automatic check(input bit ok, input string msg, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", msg, act, expv);
    end
  endtask

  task automatic push_polls(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(enc(1, 0, 8'h70));
      exp_q.push_back(enc(2, 0, 0));
    end
  endtask

  task automatic run(input bit prog, input int busyn, input bit stuck, input logic [7:0] err,
                     input int corrupt, input bit extra, input int exp_res, input string tag);
    int outcome, pairs, w;
    m_busy = busyn; m_stuck = stuck; m_err = err; m_corrupt = corrupt;
    seed = seed + 11;
    outcome = stuck ? 1 : (err != 8'h00) ? 2 : (busyn >= LIM) ? 1 : 0;
    pairs = (outcome == 1) ? LIM : busyn + 1;
    exp_q.delete();
    if (!prog) begin
      exp_q.push_back(enc(1, 0, 8'h20));
      exp_q.push_back(enc(1, 0, 8'hD0));
      push_polls(pairs);
    end else begin
      for (int a = 0; a < N; a++) begin
        exp_q.push_back(enc(1, a, 8'h40));
        exp_q.push_back(enc(1, a, int'(pat(a))));
        push_polls(pairs);
        if (outcome != 0) break;
      end
    end
    exp_q.push_back(enc(1, 0, 8'h50));
    exp_q.push_back(enc(1, 0, 8'hFF));
    if (outcome == 0)
      for (int a = 0; a < N; a++) begin
        exp_q.push_back(enc(2, a, 0));
        if (a == corrupt) break;
      end
    @(negedge clk); start = 1'b1; op_prog = prog;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, {tag, " busy after start R9"}, int'(busy), 1);
    if (extra) begin
      repeat (4) @(negedge clk);
      start = 1'b1; op_prog = ~prog;
      @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    check(done == 1'b1, {tag, " done seen R9"}, int'(done), 1);
    check(int'(result) == exp_res, {tag, " result"}, int'(result), exp_res);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, {tag, " done one cycle R9"}, int'({done, busy}), 0);
    repeat (3) @(negedge clk);
    check(int'(result) == exp_res, {tag, " result held R9"}, int'(result), exp_res);
    check(exp_q.size() == 0, {tag, " all expected accesses issued"}, exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && fl_we == 1'b0 && fl_re == 1'b0 && src_req == 1'b0,
          "R11 reset idle", int'({busy, done, fl_we, fl_re, src_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && result == 2'd0, "R11 idle after reset", int'({busy, result}), 0);
    run(1'b0, 2, 1'b0, 8'h00, -1, 1'b0, 0, "R1 R7 erase ok");
    run(1'b0, 0, 1'b0, 8'h00, -1, 1'b0, 0, "R2 erase immediate ready");
    run(1'b1, 1, 1'b0, 8'h00, -1, 1'b1, 0, "R6 R8 R10 program ok with ignored start");
    run(1'b1, 0, 1'b0, 8'h00, -1, 1'b0, 0, "R6 R8 program fast");
    run(1'b0, LIM - 1, 1'b0, 8'h00, -1, 1'b0, 0, "R4 ready on last allowed poll");
    run(1'b0, LIM, 1'b0, 8'h00, -1, 1'b0, 1, "R4 erase timeout");
    run(1'b1, 0, 1'b1, 8'h00, -1, 1'b0, 1, "R4 program timeout stops bytes");
    run(1'b0, 1, 1'b0, 8'h10, -1, 1'b0, 2, "R3 erase device error");
    run(1'b1, 0, 1'b0, 8'h08, -1, 1'b0, 2, "R3 R5 program device error");
    run(1'b0, 0, 1'b0, 8'h00, 5, 1'b0, 3, "R7 erase verify fail");
    run(1'b1, 0, 1'b0, 8'h00, 9, 1'b0, 3, "R8 program verify fail");
    run(1'b1, 0, 1'b0, 8'h00, N - 1, 1'b0, 3, "R8 verify fail last byte");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog: cycle %0d expected under %0d", cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule